// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Sticky Fault Flags

This block is a byte-wide SPI port that a small processor drives through three 8-bit registers: control, status and data. As a master it generates the serial clock from the system clock, shifts a byte out most significant bit first and captures the reply in the same eight clock periods. As a slave it follows an external clock and an active-low select input. In both modes it raises a transfer-complete flag when a byte finishes.

The block guards against misuse with sticky flags. A mode fault detects a second master pulling the select line low. When that happens the block disables itself and leaves master mode. A write collision records a data write made while a byte is moving, and that byte still completes unharmed. A select error records a slave byte cut short by the select line rising. Each flag clears only through its own register access sequence. Transfer complete and mode fault drive one level-sensitive interrupt output.

Top module: `spi_fault_ctrl`

## Requirements
- R1: Register select codes are 0 for control, 1 for status and 2 for data. Control bit 0 is enable, bit 1 is master, bit 2 disables select checking, and bits 5:3 hold the clock divider. Status bit 7 is transfer complete, bit 6 is write collision, bit 5 is select error, bit 4 is mode fault, bit 1 is master busy, and bit 0 is the synchronised select pin level. After reset, control reads 0x00, status reads 0x01 with the select pin high, and the interrupt is low.
- R2: With enable and master set and no transfer running, a data write starts an 8-bit full-duplex transfer. Data leaves on mosi_o most significant bit first, and miso_i is sampled on each rising edge of sclk_o. The serial clock idles low and each half period lasts divider+1 system clocks, so transfer complete is set 16*(divider+1) clocks after the write edge.
- R3: Transfer complete (status bit 7) sets at the end of every byte and holds irq high. It clears only when a status read that sees it set is followed by a data register access. A data read with no such prior status read leaves it set.
- R4: A data write while a byte is in progress sets write collision (status bit 6). This does not raise irq and does not change the byte being sent. Write collision clears when a status read that sees it set is followed by a data access.
- R5: When enable and master are set, select checking is enabled (control bit 2 = 0) and ss_n_i is low, mode fault (status bit 4) sets. In the same cycle irq rises and the enable and master bits clear.
- R6: Mode fault clears only when a status read that sees it set is followed by a control write. A control write with no such prior read leaves it set. Enable may be set again by that clearing write.
- R7: With control bit 2 set, ss_n_i never causes a mode fault. The pin level stays readable in status bit 0.
- R8: With enable set and master clear, a low ss_n_i selects the slave. mosi_i is shifted in on each sclk_i rising edge, most significant bit first. miso_o presents the byte written to data before the select fell. Transfer complete sets on the eighth rising edge and the byte becomes readable from data.
- R9: A byte that completes while transfer complete is still set is discarded. Data keeps returning the first byte received since the flag was last cleared.
- R10: In slave mode, ss_n_i rising after 1 to 7 bits of a byte sets select error (status bit 5) without raising irq. ss_n_i rising on a byte boundary does not set it. Select error clears only when a control write puts enable to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (triggers clear sequences) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Level interrupt request |
| sclk_o | output | 1 | Serial clock in master mode |
| mosi_o | output | 1 | Serial data out in master mode |
| miso_i | input | 1 | Serial data in for master mode |
| sclk_i | input | 1 | Serial clock in slave mode |
| mosi_i | input | 1 | Serial data in for slave mode |
| ss_n_i | input | 1 | Active-low select pin |
| miso_o | output | 1 | Serial data out in slave mode, low when not selected |

## Verification
Several rules are checked on every cycle. A rising mode fault always coincides with enable and master being dropped. A pending mode fault survives every cycle that has no control write. Mode fault never appears while select checking is disabled. Transfer complete always holds the interrupt high. The select error persists until enable is written to 0, and the master serial clock stays low whenever no transfer runs.

Only the directed scenarios can show the behaviours that depend on history and data. These are the order of the clearing sequences, the bytes exchanged in both directions, the transfer duration, a collision write leaving the outgoing byte intact, and the dropped byte on overrun. The scenarios also show that a select rise on a byte boundary is harmless.

// File: rtl/spi_fault_ctrl.sv
module spi_fault_ctrl #(
  parameter int DIV_W = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sclk_o,
  output logic       mosi_o,
  input  logic       miso_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic       ss_n_i,
  output logic       miso_o
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam int DIV_LSB = 3;

  logic en, mstr, ssdis;
  logic [DIV_W-1:0] div, tick_cnt;
  logic spif, wcol, sserr, modf;
  logic arm_spif, arm_wcol, arm_modf;
  logic [7:0] tx_buf, sh, rx, rx_buf;
  logic [2:0] cnt;
  logic busy_m, sclk_q;
  logic ss_s, ss_d, sck_s, sck_d, mosi_s;

  wire ctrl_wr  = reg_wr && reg_sel == SEL_CTRL;
  wire stat_rd  = reg_rd && reg_sel == SEL_STAT;
  wire data_wr  = reg_wr && reg_sel == SEL_DATA;
  wire data_acc = (reg_wr || reg_rd) && reg_sel == SEL_DATA;

  wire slave_on  = en && !mstr;
  wire slave_sel = slave_on && !ss_s;
  wire busy_s    = slave_sel && cnt != 3'd0;
  wire busy      = busy_m || busy_s;

  wire tick   = busy_m && tick_cnt == div;
  wire m_rise = tick && !sclk_q;
  wire m_fall = tick && sclk_q;
  wire s_rise = slave_sel && sck_s && !sck_d;
  wire s_fall = slave_sel && !sck_s && sck_d;
  wire ss_fall = !ss_s && ss_d;
  wire ss_rise = ss_s && !ss_d;

  wire m_done = m_fall && cnt == 3'd7;
  wire s_done = s_rise && cnt == 3'd7;
  wire done   = m_done || s_done;
  wire [7:0] rx_next = {rx[6:0], mstr ? miso_i : mosi_s};
  wire [7:0] rx_byte = mstr ? rx : rx_next;

  wire modf_hit  = en && mstr && !ssdis && !ss_s;
  wire start     = data_wr && en && mstr && !busy_m && !modf_hit;
  wire collide   = data_wr && busy;
  wire sserr_hit = slave_on && ss_rise && cnt != 3'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_s <= 1'b1; ss_d <= 1'b1;
      sck_s <= 1'b0; sck_d <= 1'b0; mosi_s <= 1'b0;
    end else begin
      ss_s <= ss_n_i; ss_d <= ss_s;
      sck_s <= sclk_i; sck_d <= sck_s; mosi_s <= mosi_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mstr <= 1'b0; ssdis <= 1'b0; div <= '0;
    end else begin
      if (ctrl_wr) begin
        en    <= reg_wdata[0];
        mstr  <= reg_wdata[1];
        ssdis <= reg_wdata[2];
        div   <= reg_wdata[DIV_LSB +: DIV_W];
      end
      if (modf_hit) begin
        en   <= 1'b0;
        mstr <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spif <= 1'b0; wcol <= 1'b0; sserr <= 1'b0; modf <= 1'b0;
      arm_spif <= 1'b0; arm_wcol <= 1'b0; arm_modf <= 1'b0;
      rx_buf <= '0;
    end else begin
      if (done) spif <= 1'b1;
      else if (data_acc && arm_spif) spif <= 1'b0;

      if (done && !spif) rx_buf <= rx_byte;

      if (collide) wcol <= 1'b1;
      else if (data_acc && arm_wcol) wcol <= 1'b0;

      if (modf_hit) modf <= 1'b1;
      else if (ctrl_wr && arm_modf) modf <= 1'b0;

      if (ctrl_wr && !reg_wdata[0]) sserr <= 1'b0;
      else if (sserr_hit) sserr <= 1'b1;

      if (stat_rd) begin
        arm_spif <= spif;
        arm_wcol <= wcol;
        arm_modf <= modf;
      end else begin
        if (data_acc) begin
          arm_spif <= 1'b0;
          arm_wcol <= 1'b0;
        end
        if (ctrl_wr) arm_modf <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf <= '0; sh <= '0; rx <= '0; cnt <= '0;
      busy_m <= 1'b0; sclk_q <= 1'b0; tick_cnt <= '0;
    end else begin
      if (data_wr && !busy) tx_buf <= reg_wdata;
      if (!en) begin
        busy_m <= 1'b0; sclk_q <= 1'b0; cnt <= '0; tick_cnt <= '0;
      end else if (mstr) begin
        if (start) begin
          sh <= reg_wdata; busy_m <= 1'b1; cnt <= '0;
          tick_cnt <= '0; sclk_q <= 1'b0;
        end else if (busy_m) begin
          tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
          if (m_rise) begin
            sclk_q <= 1'b1;
            rx <= rx_next;
          end
          if (m_fall) begin
            sclk_q <= 1'b0;
            sh <= {sh[6:0], 1'b0};
            cnt <= cnt + 1'b1;
            if (cnt == 3'd7) busy_m <= 1'b0;
          end
        end
      end else begin
        if (ss_s) cnt <= '0;
        if (ss_fall) begin
          sh <= tx_buf;
          cnt <= '0;
        end else if (s_rise) begin
          rx <= rx_next;
          cnt <= cnt + 1'b1;
          if (cnt == 3'd7) sh <= tx_buf;
        end else if (s_fall && cnt != 3'd0) begin
          sh <= {sh[6:0], 1'b0};
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = busy_m & sh[7];
  assign miso_o = slave_sel & sh[7];
  assign irq    = spif || (modf && !ssdis);

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_CTRL: begin
        reg_rdata[0] = en;
        reg_rdata[1] = mstr;
        reg_rdata[2] = ssdis;
        reg_rdata[DIV_LSB +: DIV_W] = div;
      end
      SEL_STAT: reg_rdata = {spif, wcol, sserr, modf, 2'b00, busy_m, ss_s};
      SEL_DATA: reg_rdata = rx_buf;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_fault_ctrl_chk.sv
module spi_fault_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_wr,
  input logic [7:0] reg_wdata,
  input logic       irq,
  input logic       spif,
  input logic       modf,
  input logic       sserr,
  input logic       en,
  input logic       mstr,
  input logic       ssdis,
  input logic       busy_m,
  input logic       sclk_o
);
  AST_MODF_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> (!en && !mstr)); // R5
  AST_MODF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (modf && !(reg_wr && reg_sel == 2'd0)) |=> modf); // R6
  AST_SSDIS_NO_MODF: assert property (@(posedge clk) disable iff (!rst_n)
    (ssdis && !modf) |=> !modf); // R7
  AST_SPIF_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    spif |-> irq); // R3
  AST_SSERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sserr && !(reg_wr && reg_sel == 2'd0 && !reg_wdata[0])) |=> sserr); // R10
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_m |-> !sclk_o); // R2
endmodule

bind spi_fault_ctrl spi_fault_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .irq(irq), .spif(spif), .modf(modf),
  .sserr(sserr), .en(en), .mstr(mstr), .ssdis(ssdis),
  .busy_m(busy_m), .sclk_o(sclk_o)
);

// File: tb/spi_fault_ctrl_bench.sv
`timescale 1ns/1ps
module spi_fault_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic irq, sclk_o, mosi_o, miso_i, miso_o;
  logic sclk_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic sl_load = 1'b0;
  logic [7:0] sl_val = '0, tb_sl, tb_got;

  always #4 clk = ~clk;

  spi_fault_ctrl u_spi_fault_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .sclk_i(sclk_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i), .miso_o(miso_o)
  );

  always @(negedge sclk_o or posedge sl_load)
    if (sl_load) tb_sl <= sl_val; else tb_sl <= {tb_sl[6:0], 1'b0};
  always @(posedge sclk_o or posedge sl_load)
    if (sl_load) tb_got <= '0; else tb_got <= {tb_got[6:0], mosi_o};
  assign miso_i = tb_sl[7];

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_irq(output int cyc);
    cyc = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) begin cyc = i + 1; break; end
    end
  endtask

  task automatic preload(input logic [7:0] v);
    sl_val = v; sl_load = 1'b1; #1 sl_load = 1'b0;
  endtask

  task automatic slave_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi_i = b[7-i];
      repeat (4) @(negedge clk);
      got = {got[6:0], miso_o};
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); check("R1 control after reset", v, 8'h00);
    rd(2'd1, v); check("R1 status after reset", v, 8'h01);
    check("R1 irq after reset", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_master;
    logic [7:0] v; int cyc;
    wr(2'd0, 8'h0B);
    rd(2'd0, v); check("R1 control readback", v, 8'h0B);
    preload(8'h3C);
    wr(2'd2, 8'hA5);
    wait_irq(cyc);
    check("R2 transfer length in clocks", 8'(cyc), 8'd32);
    check("R2 byte seen on mosi", tb_got, 8'hA5);
    rd(2'd2, v);
    rd(2'd1, v); check("R3 data read alone keeps flag", v, 8'h81);
    rd(2'd2, v); check("R2 byte captured from miso", v, 8'h3C);
    rd(2'd1, v); check("R3 flag cleared by sequence", v, 8'h01);
    check("R3 irq drops", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_wcol;
    logic [7:0] v; int cyc;
    preload(8'h00);
    wr(2'd2, 8'h11);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'hEE);
    check("R4 collision raises no irq", {7'd0, irq}, 8'h00);
    wait_irq(cyc);
    check("R4 transfer unaffected", tb_got, 8'h11);
    rd(2'd1, v); check("R4 collision flagged", v, 8'hC1);
    rd(2'd2, v);
    rd(2'd1, v); check("R4 collision cleared", v, 8'h01);
  endtask

  task automatic t_modf;
    logic [7:0] v;
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 irq on mode fault", {7'd0, irq}, 8'h01);
    rd(2'd0, v); check("R5 enable and master dropped", v, 8'h08);
    ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h08);
    check("R6 control write alone keeps fault", {7'd0, irq}, 8'h01);
    rd(2'd1, v); check("R6 fault visible", v, 8'h11);
    wr(2'd0, 8'h0B);
    check("R6 fault cleared", {7'd0, irq}, 8'h00);
    rd(2'd0, v); check("R6 enable restored", v, 8'h0B);
  endtask

  task automatic t_ssdis;
    logic [7:0] v;
    wr(2'd0, 8'h0F);
    ss_n_i = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd1, v); check("R7 no fault, pin level low", v, 8'h00);
    rd(2'd0, v); check("R7 control untouched", v, 8'h0F);
    ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_slave;
    logic [7:0] v, got; int cyc;
    wr(2'd0, 8'h01);
    wr(2'd2, 8'h96);
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    slave_bits(8'h5A, 8, got);
    check("R8 slave byte on miso", got, 8'h96);
    check("R8 slave completion irq", {7'd0, irq}, 8'h01);
    slave_bits(8'hC3, 8, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R10 boundary select rise no error", v, 8'h81);
    rd(2'd2, v); check("R9 overrun keeps first byte", v, 8'h5A);
    cyc = 0;
  endtask

  task automatic t_sserr;
    logic [7:0] v, got;
    ss_n_i = 1'b0;
    repeat (4) @(negedge clk);
    slave_bits(8'hFF, 3, got);
    ss_n_i = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd1, v); check("R10 select error set", v, 8'h21);
    check("R10 no irq from select error", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h01);
    rd(2'd2, v);
    rd(2'd1, v); check("R10 error survives other writes", v, 8'h21);
    wr(2'd0, 8'h00);
    rd(2'd1, v); check("R10 error cleared by disable", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_master;
    t_wcol;
    t_modf;
    t_ssdis;
    t_slave;
    t_sserr;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule